// File: doc/BRIEF.md
# External Bus Address-Latch and Program-Strobe Generator

This block drives the two timing strobes of an 8-bit controller's multiplexed external memory bus: the address latch strobe (high-active, `ale_o`) and the program read strobe (low-active, `psen_n_o`). A machine cycle is split into a fixed number of oscillator states, twelve by default. The sequencer elsewhere in the core supplies the current state index on `state_i`. It also marks whether the current machine cycle moves data to or from external data memory (`data_cyc_i`). The block works out by itself whether code comes from outside the chip, using the external-access input level and the program counter.

In a plain cycle the latch strobe fires twice, once in each half of the machine cycle. The program strobe fires twice as well, but only when code is fetched externally. A data-access cycle drops the second latch pulse and both program-strobe pulses, so the bus is free for the data transfer. A one-bit auxiliary register can silence the latch strobe to cut emissions. It sits at a register-bus address set by a parameter (0x8E by default), and a reset clears it. While silenced, the pin is held weakly high. External execution overrides the silence bit.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While reset is asserted and right after it, `ale_o` is 0, `ale_weak_o` is 0 and `psen_n_o` is 1.
- R2: Each output is registered. The level seen after the clock edge that samples state index s belongs to state s.
- R3: With the silence bit clear and no data access, `ale_o` is 1 for states 0–1 and 6–7 and 0 for all other states. That is two pulses of two states each per 12-state cycle.
- R4: With internal code fetch, `psen_n_o` stays 1 in every state.
- R5: With external code fetch and no data access, `psen_n_o` is 0 in states 3–4 and 9–10 and 1 in all other states.
- R6: In a data-access cycle, `ale_o` pulses only in states 0–1, and `psen_n_o` stays 1 for the whole cycle.
- R7: A code fetch is external when `ea_i` is 0, or when `pc_i` is greater than `INT_LAST`.
- R8: A register write with `reg_addr_i` equal to `REG_ADDR` (0x8E) loads bit 0 of `reg_wdata_i` into the silence bit. Writes to any other address leave the bit unchanged.
- R9: With the silence bit set and internal code fetch, `ale_o` is held at 1 and `ale_weak_o` is 1 in every state.
- R10: With external code fetch, the silence bit has no effect. `ale_o` follows R3/R6 and `ale_weak_o` is 0.
- R11: Reset clears the silence bit.
- R12: A driven `ale_o` high never coincides with `psen_n_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-state clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| state_i | input | STATE_W | Current state index inside the machine cycle, 0..STATES-1 |
| data_cyc_i | input | 1 | Current machine cycle performs an external data access |
| ea_i | input | 1 | External-access pin level (0 forces external code) |
| pc_i | input | PC_W | Program counter of the current fetch |
| reg_we_i | input | 1 | Register-bus write strobe |
| reg_addr_i | input | 8 | Register-bus address |
| reg_wdata_i | input | 8 | Register-bus write data |
| ale_o | output | 1 | Address latch strobe level |
| ale_weak_o | output | 1 | Latch pin is only weakly pulled high (strobe silenced) |
| psen_n_o | output | 1 | Program read strobe, active low |

## Verification
The bench builds the block with `PC_W = 8` and `INT_LAST = 8'h7F`, keeping the default 12 states and two-state strobes. This shrinks the internal code space so that the boundary just below it (0x7F), the first external address (0x80) and the address-space top (0xFF) can all be swept cheaply. The sweep covers every combination of external-access level, these program-counter values, data-access flag and silence bit, state by state across whole machine cycles. Pulse counts per machine cycle are then compared with arithmetic expectations.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  // True when state s falls inside the strobe window [start, start+len)
  function automatic logic in_window(int unsigned s, int unsigned start, int unsigned len);
    return (s >= start) && (s < start + len);
  endfunction

  // Code fetch leaves the chip when EA is low or PC runs past internal space
  function automatic logic fetch_is_ext(logic ea, int unsigned pc, int unsigned last);
    return !ea || (pc > last);
  endfunction
endpackage

// File: rtl/xbs_fetch_sel.sv
module xbs_fetch_sel #(
  parameter int PC_W     = 16,
  parameter int INT_LAST = 16'h1FFF
) (
  input  logic            ea_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            fetch_ext_o
);
  import xbs_pkg::*;
  always_comb fetch_ext_o = fetch_is_ext(ea_i, 32'(pc_i), INT_LAST);
endmodule

// File: rtl/xbs_silence_reg.sv
module xbs_silence_reg #(
  parameter logic [7:0] REG_ADDR = 8'h8E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       silence_o
);
  logic hit;
  assign hit = we_i && (addr_i == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   silence_o <= 1'b0;
    else if (hit) silence_o <= wdata_i[0];
  end

  // R11: coming out of reset the bit is clear
  p_reset_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !silence_o);
  // R8: foreign addresses do not touch the bit
  p_foreign_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i != REG_ADDR) |=> $stable(silence_o));
endmodule

// File: rtl/xbs_pattern.sv
module xbs_pattern #(
  parameter int STATES   = 12,
  parameter int STROBE   = 2,
  parameter int ALE_OFS  = 0,
  parameter int PSEN_OFS = 3,
  parameter int STATE_W  = $clog2(STATES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               data_cyc_i,
  input  logic               fetch_ext_i,
  input  logic               silence_i,
  output logic               ale_o,
  output logic               ale_weak_o,
  output logic               psen_n_o
);
  import xbs_pkg::*;
  localparam int HALF = STATES / 2;

  int unsigned st;
  logic ale_first, ale_second, ps_first, ps_second;
  logic hold_high, ale_next, psen_n_next;

  always_comb begin
    st          = 32'(state_i);
    ale_first   = in_window(st, ALE_OFS, STROBE);
    ale_second  = in_window(st, HALF + ALE_OFS, STROBE) && !data_cyc_i;
    ps_first    = in_window(st, PSEN_OFS, STROBE);
    ps_second   = in_window(st, HALF + PSEN_OFS, STROBE);
    hold_high   = silence_i && !fetch_ext_i;
    ale_next    = hold_high ? 1'b1 : (ale_first || ale_second);
    psen_n_next = !(fetch_ext_i && !data_cyc_i && (ps_first || ps_second));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_o      <= 1'b0;
      ale_weak_o <= 1'b0;
      psen_n_o   <= 1'b1;
    end else begin
      ale_o      <= ale_next;
      ale_weak_o <= hold_high;
      psen_n_o   <= psen_n_next;
    end
  end

  // R4: internal fetch never strobes program memory
  p_psen_internal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fetch_ext_i) |-> psen_n_o);
  // R6: data cycles carry no program strobe
  p_psen_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_cyc_i) |-> psen_n_o);
  // R9: silenced strobe sits weakly high on internal execution
  p_ale_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(silence_i && !fetch_ext_i) |-> (ale_o && ale_weak_o));
  // R10: external execution always drives the strobe
  p_ale_override_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fetch_ext_i) |-> !ale_weak_o);
  // R12: driven latch strobe and program strobe never overlap
  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_o && !ale_weak_o && !psen_n_o));
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen #(
  parameter int         STATES   = 12,
  parameter int         STROBE   = 2,
  parameter int         PSEN_OFS = 3,
  parameter int         PC_W     = 16,
  parameter int         INT_LAST = 16'h1FFF,
  parameter logic [7:0] REG_ADDR = 8'h8E,
  localparam int        STATE_W  = $clog2(STATES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               data_cyc_i,
  input  logic               ea_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               reg_we_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic               ale_o,
  output logic               ale_weak_o,
  output logic               psen_n_o
);
  logic fetch_ext;
  logic silence;

  xbs_fetch_sel #(.PC_W(PC_W), .INT_LAST(INT_LAST)) u_fetch (
    .ea_i(ea_i), .pc_i(pc_i), .fetch_ext_o(fetch_ext));

  xbs_silence_reg #(.REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .silence_o(silence));

  xbs_pattern #(.STATES(STATES), .STROBE(STROBE), .ALE_OFS(0),
                .PSEN_OFS(PSEN_OFS), .STATE_W(STATE_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .state_i(state_i), .data_cyc_i(data_cyc_i),
    .fetch_ext_i(fetch_ext), .silence_i(silence),
    .ale_o(ale_o), .ale_weak_o(ale_weak_o), .psen_n_o(psen_n_o));

  // R7: EA low always means an external fetch, so the program strobe runs
  p_ea_low_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ea_i && !data_cyc_i) && $past(32'(state_i)) == PSEN_OFS) |-> !psen_n_o);
endmodule

// File: tb/sim_xbus_strobe_gen.sv
module sim_xbus_strobe_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] state = 4'd11;
  logic data_cyc = 1'b0, ea = 1'b1;
  logic [7:0] pc = 8'h00;
  logic we = 1'b0;
  logic [7:0] waddr = 8'h00, wdata = 8'h00;
  logic ale, ale_weak, psen_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xbus_strobe_gen #(.PC_W(8), .INT_LAST(8'h7F)) u0 (
    .clk(clk), .rst_n(rst_n), .state_i(state), .data_cyc_i(data_cyc), .ea_i(ea),
    .pc_i(pc), .reg_we_i(we), .reg_addr_i(waddr), .reg_wdata_i(wdata),
    .ale_o(ale), .ale_weak_o(ale_weak), .psen_n_o(psen_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); state = 4'd11; we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // One machine cycle, state-by-state and per-cycle pulse counts
  task automatic cycle(input logic e, input logic [7:0] p, input logic d, input logic sil);
    bit ext = (e == 1'b0) || (p >= 8'h80);                 // R7
    bit quiet = sil && !ext;
    int ale_n = 0, ps_n = 0;
    for (int s = 0; s < 12; s++) begin
      int ea_exp, ps_exp;
      @(negedge clk); state = 4'(s); ea = e; pc = p; data_cyc = d;
      @(posedge clk); #1;                                    // R2: one register
      if (quiet) ea_exp = 1;                                 // R9
      else ea_exp = ((s / 2) == 0 || ((s / 2) == 3 && !d)) ? 1 : 0; // R3 R6 R10
      ps_exp = (ext && !d && ((s % 6) == 3 || (s % 6) == 4)) ? 0 : 1; // R4 R5 R6
      chk(quiet ? "R9" : (ext ? "R10" : "R3"), ale, ea_exp);
      chk(quiet ? "R9 weak" : "R10 weak", ale_weak, quiet ? 1 : 0);
      chk(ext ? "R5" : "R4", psen_n, ps_exp);
      chk("R12", (ale && !ale_weak && !psen_n) ? 1 : 0, 0);
      if (ale && !ale_weak) ale_n++;
      if (!psen_n) ps_n++;
    end
    chk(d ? "R6 ale count" : "R3 ale count", ale_n, quiet ? 0 : (d ? 2 : 4));
    chk(d ? "R6 psen count" : "R5 psen count", ps_n, (ext && !d) ? 4 : 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pcs [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    repeat (3) @(posedge clk); #1;
    chk("R1 ale", ale, 0); chk("R1 weak", ale_weak, 0); chk("R1 psen", psen_n, 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", psen_n, 1);
    for (int sil = 0; sil < 2; sil++) begin
      wr(8'h8E, 8'(sil));                                    // R8
      for (int e = 0; e < 2; e++)
        for (int k = 0; k < 4; k++)
          for (int d = 0; d < 2; d++)
            cycle(1'(e), pcs[k], 1'(d), 1'(sil));
    end
    // R8: write to a neighbouring address is ignored (bit stays set)
    wr(8'h8F, 8'h00);
    cycle(1'b1, 8'h10, 1'b0, 1'b1);
    // R8: only bit 0 matters
    wr(8'h8E, 8'hFE);
    cycle(1'b1, 8'h10, 1'b0, 1'b0);
    wr(8'h8D, 8'hFF);
    cycle(1'b1, 8'h10, 1'b0, 1'b0);
    // R11: reset clears the silence bit
    wr(8'h8E, 8'h01);
    cycle(1'b1, 8'h20, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cycle(1'b1, 8'h20, 1'b0, 1'b0);                          // R11 via normal ALE
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule